// File: doc/BRIEF.md
# Reloading Countdown Digital Oscillator

This block is the oscillator stage of a digital phase-locked loop. A down-counter runs on the system clock and, each time its content reaches zero, a zero detector raises a single-cycle output pulse. In that same cycle the counter is reloaded with the difference between a fixed base count and a signed correction number supplied by the loop filter. The output period is therefore the base count minus the correction, in clock cycles, and with no correction the oscillator free-runs at the clock frequency divided by the base count.

The difference is formed the way a hardware subtractor does it: the correction is sign-extended, complemented, incremented and added to the base. The result is held at a floor of two cycles so that a large positive correction can never stop or wrap the counter. A square-wave output flips state on every pulse, giving a half-rate clock with a 50% duty cycle when the period is steady.

Top module: `reloading_countdown_dco`

## Requirements
- R1: While `rst_n` is low, `pulse_o` and `square_o` are 0; after release the first pulse is seen in the cycle that follows the (BASE-1)th rising edge of `clk` with `rst_n` high.
- R2: Between reloads the counter steps down by one on every rising edge, so successive pulses are spaced by exactly the reload value in cycles.
- R3: With `k_i` equal to 0 the spacing between pulses is BASE cycles (100 by default).
- R4: `k_i` is a two's-complement signed number; the spacing after a reload is BASE minus `k_i`, lengthening for negative and shortening for positive values.
- R5: `k_i` is taken only in the cycle where `pulse_o` is 1; a change during a period leaves that period's length untouched and sets the length of the next one.
- R6: When BASE minus `k_i` is below 2, the spacing is 2 cycles.
- R7: `pulse_o` is high for one cycle only per period.
- R8: `square_o` inverts on the rising edge that ends a pulse cycle and stays steady at every other edge.
- R9: The most negative `k_i` (-128 at the default 8-bit width) gives a spacing of BASE+128 cycles with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_i | input | CTL_W (8) | Signed correction number from the loop filter |
| pulse_o | output | 1 | One-cycle pulse at each zero detect |
| square_o | output | 1 | Square wave that toggles at every pulse |

## Verification
The pulse is decoded straight from the counter register, so a reload taken at edge n gives the next pulse in the cycle after edge n plus the reload value; the bench measures spacing by counting falling edges from one sampled pulse to the next. The square wave is registered and flips in the cycle right after a pulse, so it is sampled one falling edge after the pulse and again at the next pulse. A correction change is applied at a falling edge five cycles into a period, and the bench expects the old length for that period and the new one for the following period.

// File: rtl/rcdco_pkg.sv
package rcdco_pkg;

  // Smallest reload value; keeps at least one idle cycle between pulses
  localparam int unsigned RELOAD_FLOOR = 2;

  // Largest magnitude a signed correction of the given width can take
  function automatic int unsigned ctl_span(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

  // Counter width needed to hold the longest possible period
  function automatic int unsigned cnt_width(input int unsigned base, input int unsigned ctl_w);
    return $clog2(base + ctl_span(ctl_w) + 1);
  endfunction

endpackage

// File: rtl/dco_reload_calc.sv
module dco_reload_calc
  import rcdco_pkg::*;
#(
  parameter int unsigned BASE  = 100,
  parameter int unsigned CTL_W = 8,
  parameter int unsigned CNT_W = 9
) (
  input  logic signed [CTL_W-1:0] k_i,
  output logic        [CNT_W-1:0] reload_o
);

  localparam int unsigned SUM_W = CNT_W + 1;

  // Two's-complement negate then add, all in a signed width one bit wider
  function automatic logic signed [SUM_W-1:0] base_minus(input logic signed [CTL_W-1:0] k);
    logic signed [SUM_W-1:0] k_ext;
    logic signed [SUM_W-1:0] k_neg;
    k_ext = SUM_W'(k);
    k_neg = ~k_ext + SUM_W'(1);
    return SUM_W'(BASE) + k_neg;
  endfunction

  logic signed [SUM_W-1:0] diff;
  logic                    below_floor;

  always_comb begin
    diff        = base_minus(k_i);
    below_floor = diff < $signed(SUM_W'(RELOAD_FLOOR));
    reload_o    = below_floor ? CNT_W'(RELOAD_FLOOR) : diff[CNT_W-1:0];
  end

endmodule

// File: rtl/dco_countdown.sv
module dco_countdown #(
  parameter int unsigned BASE  = 100,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_i,
  output logic             zero_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // The zero cycle counts as the last cycle of the period, so load one less
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(BASE - 1);
    else if (zero_o) cnt_q <= reload_i - CNT_W'(1);
    else             cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_o |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_reload_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |=> cnt_q == $past(reload_i) - CNT_W'(1));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |=> !zero_o);

endmodule

// File: rtl/dco_square.sv
module dco_square (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic sq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sq_o <= 1'b0;
    else if (tick_i) sq_o <= ~sq_o;
  end

  assert_flip_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> sq_o != $past(sq_o));

  assert_hold_off_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(sq_o));

endmodule

// File: rtl/reloading_countdown_dco.sv
module reloading_countdown_dco
  import rcdco_pkg::*;
#(
  parameter int unsigned BASE  = 100,
  parameter int unsigned CTL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CTL_W-1:0] k_i,
  output logic                    pulse_o,
  output logic                    square_o
);

  localparam int unsigned CNT_W = cnt_width(BASE, CTL_W);

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_val;
  logic             zero_hit;

  dco_reload_calc #(.BASE(BASE), .CTL_W(CTL_W), .CNT_W(CNT_W)) u_calc (
    .k_i      (k_i),
    .reload_o (reload_val)
  );

  dco_countdown #(.BASE(BASE), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (reload_val),
    .zero_o   (zero_hit),
    .cnt_o    (cnt_val)
  );

  dco_square u_sq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (zero_hit),
    .sq_o   (square_o)
  );

  assign pulse_o = zero_hit;

  assert_reload_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_val >= CNT_W'(RELOAD_FLOOR));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_val <= CNT_W'(BASE + ctl_span(CTL_W)));

endmodule

// File: tb/sim_reloading_countdown_dco.sv
`timescale 1ns/1ps
module sim_reloading_countdown_dco;

  localparam int BASE  = 100;
  localparam int CTL_W = 8;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic signed [CTL_W-1:0] k_i = '0;
  logic                    pulse_o;
  logic                    square_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  reloading_countdown_dco #(.BASE(BASE), .CTL_W(CTL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .k_i(k_i), .pulse_o(pulse_o), .square_o(square_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count falling edges until the next pulse is seen
  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse_o);
  endtask

  task automatic to_pulse();
    while (!pulse_o) @(negedge clk);
  endtask

  task automatic period_for(input int k, input int exp, input string req);
    int n;
    k_i = CTL_W'(k);
    to_pulse();
    measure(n);
    check(req, n, exp);
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk);
    check("R1 pulse in reset", int'(pulse_o), 0);
    check("R1 square in reset", int'(square_o), 0);
    rst_n = 1'b1;
    measure(n);
    check("R1 first pulse", n, BASE - 1);
  endtask

  task automatic t_steady();
    for (int i = 0; i < 3; i++) period_for(0, BASE, "R2 R3 free run");
  endtask

  task automatic t_signed();
    period_for(30, BASE - 30, "R4 positive k");
    period_for(-50, BASE + 50, "R4 negative k");
    period_for(-128, BASE + 128, "R9 most negative k");
  endtask

  task automatic t_floor();
    period_for(97, 3, "R6 just above floor");
    period_for(98, 2, "R6 at floor");
    period_for(127, 2, "R6 clamped");
    @(negedge clk);
    check("R7 pulse one cycle", int'(pulse_o), 0);
  endtask

  task automatic t_midchange();
    int n;
    k_i = '0;
    to_pulse();
    n = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      n++;
    end
    k_i = CTL_W'(20);
    while (!pulse_o) begin
      @(negedge clk);
      n++;
    end
    check("R5 current period unchanged", n, BASE);
    measure(n);
    check("R5 next period uses new k", n, BASE - 20);
  endtask

  task automatic t_square();
    int s0, n;
    k_i = '0;
    to_pulse();
    s0 = int'(square_o);
    @(negedge clk);
    check("R8 flip after pulse", int'(square_o), 1 - s0);
    check("R7 pulse drops", int'(pulse_o), 0);
    measure(n);
    check("R8 held until next pulse", int'(square_o), 1 - s0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_steady();
    t_signed();
    t_floor();
    t_midchange();
    t_square();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule